// File: doc/BRIEF.md
# Mixed-Width Shared Nibble Memory

This block is a two-port memory whose ports look at one common store through windows of different width. The wide port works with 8-bit words selected by an 8-bit address. The narrow port works with 4-bit words selected by a 9-bit address. Both ports sit on the same clock, and each port can read and write. The store holds 2048 bits, arranged as 512 nibbles.

A wide word is made of two neighbouring nibbles. The nibble at the even narrow address carries the upper half of the wide word. Reads are registered on both ports. A port that is not enabled keeps its last output. When both ports write the same nibble in one cycle, the wide port's value is stored.

Top module: `asym_dpram`

## Requirements
- R1: The wide port uses an 8-bit address and 8-bit data. The narrow port uses a 9-bit address and 4-bit data. Together they address 512 distinct 4-bit cells, and every cell holds its own value.
- R2: Wide address a covers narrow addresses {a,0} and {a,1}. The nibble at {a,0} is wide bits 7:4, and the nibble at {a,1} is wide bits 3:0. This holds in both directions: a wide write is seen by narrow reads, and narrow writes are seen by wide reads.
- R3: A narrow write changes only its own nibble. The other half of the wide word keeps its value.
- R4: A read with the port's enable high presents its data on the read output after the next rising clock edge, one cycle of latency.
- R5: A write on a port returns, on that same port's read output, the content the location held before the write (read-first).
- R6: A port that reads a location in the cycle the other port writes it returns the old content.
- R7: When both ports write the same nibble in one cycle, the wide port's data is stored. A narrow write that falls inside the wide port's pair is discarded.
- R8: With a port's enable low, its read output holds its previous value. No write takes place, even if the write-enable is high.
- R9: An active-low reset clears both read outputs to zero and leaves the stored contents untouched.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Common clock, rising edge |
| rst_n | input | 1 | Active-low reset of the read output registers |
| wa_en | input | 1 | Wide port enable |
| wa_we | input | 1 | Wide port write enable |
| wa_addr | input | 8 | Wide port word address |
| wa_wdata | input | 8 | Wide port write data |
| wa_rdata | output | 8 | Wide port registered read data |
| nb_en | input | 1 | Narrow port enable |
| nb_we | input | 1 | Narrow port write enable |
| nb_addr | input | 9 | Narrow port nibble address |
| nb_wdata | input | 4 | Narrow port write data |
| nb_rdata | output | 4 | Narrow port registered read data |

## Verification
The memory is first filled through the wide port with an address-dependent pattern. Every nibble is then read back through the narrow port and every word through the wide port. This separates a swapped nibble order from a correct one, and aliased cells from distinct ones.

Sparse narrow writes followed by wide reads show whether the partner nibble is disturbed. Same-cycle traffic is then driven in several forms:
- a read and a write on one port, to show read-first order;
- a read on one port and a write on the other, to show that cross-port reads return old data;
- both ports writing one nibble, to show which port wins.

Cycles with the enable low but the write-enable high show the difference between holding the output and writing silently. A reset in the middle of the run shows that it clears only the outputs.

// File: rtl/asym_dpram.sv
module asym_dpram #(
  parameter int NIB_W    = 4,
  parameter int N_ADDR_W = 9
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  wa_en,
  input  logic                  wa_we,
  input  logic [N_ADDR_W-2:0]   wa_addr,
  input  logic [2*NIB_W-1:0]    wa_wdata,
  output logic [2*NIB_W-1:0]    wa_rdata,
  input  logic                  nb_en,
  input  logic                  nb_we,
  input  logic [N_ADDR_W-1:0]   nb_addr,
  input  logic [NIB_W-1:0]      nb_wdata,
  output logic [NIB_W-1:0]      nb_rdata
);
  localparam int DEPTH = 1 << N_ADDR_W;
  localparam int WW    = 2 * NIB_W;

  logic [NIB_W-1:0] mem [DEPTH];

  logic [N_ADDR_W-1:0] a_hi, a_lo;
  logic a_wr, b_wr, b_shadowed;

  assign a_hi       = {wa_addr, 1'b0};
  assign a_lo       = {wa_addr, 1'b1};
  assign a_wr       = wa_en & wa_we;
  assign b_wr       = nb_en & nb_we;
  assign b_shadowed = a_wr && (nb_addr[N_ADDR_W-1:1] == wa_addr);

  always_ff @(posedge clk) begin
    if (b_wr && !b_shadowed) mem[nb_addr] <= nb_wdata;
    if (a_wr) begin
      mem[a_hi] <= wa_wdata[WW-1:NIB_W];
      mem[a_lo] <= wa_wdata[NIB_W-1:0];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wa_rdata <= '0;
      nb_rdata <= '0;
    end else begin
      if (wa_en) wa_rdata <= {mem[a_hi], mem[a_lo]};
      if (nb_en) nb_rdata <= mem[nb_addr];
    end
  end
endmodule

// File: rtl/asym_dpram_chk.sv
module asym_dpram_chk #(
  parameter int NIB_W    = 4,
  parameter int N_ADDR_W = 9
) (
  input logic                clk,
  input logic                rst_n,
  input logic                wa_en,
  input logic                wa_we,
  input logic [N_ADDR_W-2:0] wa_addr,
  input logic [2*NIB_W-1:0]  wa_wdata,
  input logic [2*NIB_W-1:0]  wa_rdata,
  input logic                nb_en,
  input logic                nb_we,
  input logic [N_ADDR_W-1:0] nb_addr,
  input logic [NIB_W-1:0]    nb_wdata,
  input logic [NIB_W-1:0]    nb_rdata
);
  localparam int WW = 2 * NIB_W;

  assert_wide_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !wa_en |=> $stable(wa_rdata));

  assert_narrow_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !nb_en |=> $stable(nb_rdata));

  assert_upper_nibble_map_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (nb_en && !nb_we && $past(wa_en && wa_we) && nb_addr == {$past(wa_addr), 1'b0})
    |=> nb_rdata == $past(wa_wdata[WW-1:NIB_W], 2));

  assert_lower_nibble_map_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (wa_en && !wa_we && $past(nb_en && nb_we) && !$past(wa_en && wa_we) &&
     wa_addr == $past(nb_addr[N_ADDR_W-1:1]) && $past(nb_addr[0]))
    |=> wa_rdata[NIB_W-1:0] == $past(nb_wdata, 2));

  assert_wide_wins_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (nb_en && !nb_we && $past(wa_en && wa_we && nb_en && nb_we) &&
     nb_addr == $past(nb_addr) && $past(nb_addr[N_ADDR_W-1:1] == wa_addr))
    |=> nb_rdata == ($past(nb_addr[0], 2) ? $past(wa_wdata[NIB_W-1:0], 2)
                                          : $past(wa_wdata[WW-1:NIB_W], 2)));
endmodule

bind asym_dpram asym_dpram_chk #(.NIB_W(NIB_W), .N_ADDR_W(N_ADDR_W)) chk_i (
  .clk(clk), .rst_n(rst_n),
  .wa_en(wa_en), .wa_we(wa_we), .wa_addr(wa_addr), .wa_wdata(wa_wdata), .wa_rdata(wa_rdata),
  .nb_en(nb_en), .nb_we(nb_we), .nb_addr(nb_addr), .nb_wdata(nb_wdata), .nb_rdata(nb_rdata)
);

// File: tb/asym_dpram_tb_top.sv
module asym_dpram_tb_top;
  localparam int PERIOD = 10;
  localparam int NW = 4;
  localparam int NA = 9;
  localparam int WW = 2 * NW;
  localparam int WA = NA - 1;

  logic clk = 0, rst_n = 0;
  logic wa_en = 0, wa_we = 0, nb_en = 0, nb_we = 0;
  logic [WA-1:0] wa_addr = '0;
  logic [WW-1:0] wa_wdata = '0, wa_rdata;
  logic [NA-1:0] nb_addr = '0;
  logic [NW-1:0] nb_wdata = '0, nb_rdata;

  int total = 0, bad = 0;
  logic [NW-1:0] model [1 << NA];
  logic [WW-1:0] exp_a = '0;
  logic [NW-1:0] exp_b = '0;
  logic [WW-1:0] qa_d [$];
  logic [NW-1:0] qb_d [$];
  string qa_r [$], qb_r [$];

  always #(PERIOD/2) clk = ~clk;

  asym_dpram dut_i (
    .clk(clk), .rst_n(rst_n),
    .wa_en(wa_en), .wa_we(wa_we), .wa_addr(wa_addr), .wa_wdata(wa_wdata), .wa_rdata(wa_rdata),
    .nb_en(nb_en), .nb_we(nb_we), .nb_addr(nb_addr), .nb_wdata(nb_wdata), .nb_rdata(nb_rdata)
  );

  task automatic chk(string r, logic [WW-1:0] act, logic [WW-1:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%h expected=%h", r, act, exp);
    end
  endtask

  task automatic cyc(logic ae, logic awe, logic [WA-1:0] aa, logic [WW-1:0] ad,
                     logic be, logic bwe, logic [NA-1:0] ba, logic [NW-1:0] bd, string r);
    @(negedge clk);
    wa_en = ae; wa_we = awe; wa_addr = aa; wa_wdata = ad;
    nb_en = be; nb_we = bwe; nb_addr = ba; nb_wdata = bd;
    if (ae) exp_a = {model[{aa, 1'b0}], model[{aa, 1'b1}]};
    if (be) exp_b = model[ba];
    if (be && bwe) model[ba] = bd;
    if (ae && awe) begin
      model[{aa, 1'b0}] = ad[WW-1:NW];
      model[{aa, 1'b1}] = ad[NW-1:0];
    end
    qa_d.push_back(exp_a); qa_r.push_back(r);
    qb_d.push_back(exp_b); qb_r.push_back(r);
  endtask

  always @(posedge clk) begin
    #1;
    if (qa_d.size() > 0) chk({qa_r.pop_front(), " wide"}, wa_rdata, qa_d.pop_front());
    if (qb_d.size() > 0) chk({qb_r.pop_front(), " narrow"}, {{NW{1'b0}}, nb_rdata}, {{NW{1'b0}}, qb_d.pop_front()});
  end

  task automatic do_reset();
    @(negedge clk);
    wa_en = 0; wa_we = 0; nb_en = 0; nb_we = 0;
    rst_n = 0;
    @(negedge clk);
    chk("R9 reset wide", wa_rdata, '0);
    chk("R9 reset narrow", {{NW{1'b0}}, nb_rdata}, '0);
    rst_n = 1;
    exp_a = '0; exp_b = '0;
  endtask

  initial begin
    #(PERIOD * 100000);
    total++; bad++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    for (int i = 0; i < (1 << NA); i++) model[i] = 'x;
    repeat (2) @(negedge clk);
    chk("R9 reset wide", wa_rdata, '0);
    chk("R9 reset narrow", {{NW{1'b0}}, nb_rdata}, '0);
    rst_n = 1;

    for (int a = 0; a < (1 << WA); a++)
      cyc(1, 1, a[WA-1:0], a[WW-1:0] ^ 8'h5A, 0, 0, '0, '0, "R1 fill");
    for (int n = 0; n < (1 << NA); n++)
      cyc(0, 0, '0, '0, 1, 0, n[NA-1:0], '0, "R2 narrow view of wide data");
    for (int a = 0; a < (1 << WA); a += 3)
      cyc(1, 0, a[WA-1:0], '0, 0, 0, '0, '0, "R4 wide readback latency");

    cyc(0, 0, '0, '0, 1, 1, 9'h021, 4'hC, "R3 narrow write odd");
    cyc(0, 0, '0, '0, 1, 1, 9'h040, 4'h3, "R3 narrow write even");
    cyc(1, 0, 8'h10, '0, 0, 0, '0, '0, "R3 partner nibble kept");
    cyc(1, 0, 8'h20, '0, 0, 0, '0, '0, "R3 partner nibble kept");
    cyc(1, 0, 8'h20, '0, 1, 0, 9'h041, '0, "R2 both views agree");

    cyc(1, 1, 8'h33, 8'hE7, 0, 0, '0, '0, "R5 wide read-first");
    cyc(1, 0, 8'h33, '0, 0, 0, '0, '0, "R5 wide new data");
    cyc(0, 0, '0, '0, 1, 1, 9'h0AB, 4'h9, "R5 narrow read-first");
    cyc(0, 0, '0, '0, 1, 0, 9'h0AB, '0, "R5 narrow new data");

    cyc(1, 1, 8'h44, 8'h12, 1, 0, 9'h088, '0, "R6 narrow reads during wide write");
    cyc(1, 0, 8'h55, '0, 1, 1, 9'h0AB, 4'h6, "R6 wide reads during narrow write");
    cyc(1, 0, 8'h44, '0, 1, 0, 9'h088, '0, "R6 after writes");

    cyc(1, 1, 8'h60, 8'hAB, 1, 1, 9'h0C0, 4'h1, "R7 collision upper");
    cyc(1, 1, 8'h61, 8'hCD, 1, 1, 9'h0C3, 4'h2, "R7 collision lower");
    cyc(1, 1, 8'h62, 8'hEF, 1, 1, 9'h0C6, 4'h7, "R7 disjoint writes");
    cyc(0, 0, '0, '0, 1, 0, 9'h0C0, '0, "R7 wide wins upper");
    cyc(0, 0, '0, '0, 1, 0, 9'h0C3, '0, "R7 wide wins lower");
    cyc(1, 0, 8'h63, '0, 1, 0, 9'h0C6, '0, "R7 disjoint narrow stored");

    cyc(0, 1, 8'h70, 8'h00, 0, 1, 9'h0E0, 4'h0, "R8 disabled hold");
    cyc(0, 1, 8'h71, 8'hFF, 0, 1, 9'h0E3, 4'hF, "R8 disabled hold");
    cyc(1, 0, 8'h70, '0, 1, 0, 9'h0E3, '0, "R8 no write when disabled");
    cyc(1, 0, 8'h71, '0, 1, 0, 9'h0E0, '0, "R8 no write when disabled");

    do_reset();
    cyc(1, 0, 8'h33, '0, 1, 0, 9'h0AB, '0, "R9 contents survive reset");
    cyc(0, 0, '0, '0, 0, 0, '0, '0, "R8 idle");
    cyc(0, 0, '0, '0, 0, 0, '0, '0, "R8 idle");
    repeat (3) @(negedge clk);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule